// File: doc/BRIEF.md
# ADC Control Front End with Conversion-Flag Clearing

This block is the digital control front end of a multi-channel successive-approximation ADC. It holds one 8-bit control word that switches the converter's power, selects how conversion-complete flags are cleared, decides whether the converter sleeps in wait mode, and configures an external start trigger. It also keeps one conversion-complete flag and one captured result for each result slot, together with a sequence-complete flag that can raise an interrupt.

The block connects to a register bus, to the system's wait-mode entry and wake signals, to a trigger pin shared with analog channel 15, and to a conversion sequencer. From the sequencer it takes per-slot done strobes, shared result data and a sequence-complete strobe. To the sequencer it sends abort, halt, power, ready and trigger-start signals. After power-up, and again after wake from a powered-down wait, a programmable settling count passes before any conversion result is accepted. Any write to the control word aborts the sequence that is running and does not start a new one.

Top module: `adc_ctrl_front`

## Requirements
- R1: After reset the control word reads 0x00, all conversion-complete flags read 0, and conv_power, conv_ready, seq_abort, seq_halt, trig_start and irq are all 0.
- R2: The control word is at bus address 0. Bit 7 is power, bit 6 is fast clear, bit 5 is wait power-down, bit 4 is level (1) or edge (0) trigger, bit 3 is trigger polarity (1 = rising or high), bit 2 is trigger enable, bit 1 is interrupt enable, and bit 0 is the sequence-complete flag. Bits 7..1 read back as written. Writes to bit 0 are ignored.
- R3: Every write to address 0 drives seq_abort high for exactly the following cycle and clears the sequence-complete flag. A write to address 0 does not assert trig_start.
- R4: conv_power follows the power bit unless the block is halted. conv_ready rises exactly RECOVERY_CYCLES clock edges after conv_power rises.
- R5: A conv_done strobe, or a seq_done strobe, that arrives while conv_ready is 0 is ignored.
- R6: In normal mode (bit 6 = 0), flag i is read at address STAT_BASE + i/8, bit i%8. The flag clears only when result i (address RES_BASE + i) is read after a status read that saw the flag set. A result read on its own leaves the flag set.
- R7: In normal mode, any bus write that falls between the status read and the result read cancels the pairing, and the flag stays set.
- R8: In fast mode (bit 6 = 1), any read or write of result i clears flag i.
- R9: While in wait mode with wait power-down set, seq_halt is 1 and conv_power is 0. With wait power-down clear, wait mode changes neither signal.
- R10: A wake pulse ends wait mode. The recovery count then starts again, so a done strobe in the first cycles after wake is dropped.
- R11: With trigger enable set and the block ready, trig_start reacts to the pin through a 2-flop synchronizer. In edge mode it pulses for one cycle on a rising or falling pin edge. In level mode it stays high while the pin is at the selected level.
- R12: With trigger enable clear, trig_start stays 0 whatever the pin does. ch15_is_trig equals control bit 2.
- R13: A seq_done strobe while ready sets the sequence-complete flag. irq is 1 exactly when that flag and the interrupt enable bit are both 1.
- R14: Reading result i returns the conv_data value captured on the last accepted conv_done[i] strobe, zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| wait_enter | input | 1 | Pulse: device enters wait mode |
| wake | input | 1 | Pulse: interrupt wake from wait mode |
| ext_trig_pin | input | 1 | Asynchronous trigger pin (channel 15) |
| conv_done | input | NUM_RESULTS | Per-slot conversion-done strobes |
| conv_data | input | DATA_W | Result data for the strobed slot |
| seq_done | input | 1 | Sequence-complete strobe from the sequencer |
| seq_abort | output | 1 | One-cycle abort request to the sequencer |
| seq_halt | output | 1 | Sequencer halt while powered down in wait |
| conv_power | output | 1 | Analog power enable |
| conv_ready | output | 1 | Power on and recovery elapsed |
| trig_start | output | 1 | Start request from the external trigger |
| ch15_is_trig | output | 1 | Channel 15 is used as the trigger input |
| irq | output | 1 | Sequence-complete interrupt request |

## Verification
The bench builds the block with NUM_RESULTS = 12 and RECOVERY_CYCLES = 5. With 12 slots, the second status byte is only half filled, so the bench can check that its unused upper bits read 0. With a recovery count of 5, the bench can walk the settling window edge by edge, after power-up and again after wake. Directed cases cover all four trigger sensitivities, the disarming of a pairing by an intervening write, and wait mode with and without power-down. A seeded random phase mixes strobes, status reads, result reads and writes, and control writes that switch the clear mode, and checks them against a flag-and-arm model kept in the bench.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

   localparam int BUS_W = 8;

   // control word layout, MSB first; software depends on these positions
   typedef struct packed {
      logic pwr;    // 7
      logic ffc;    // 6
      logic wpd;    // 5
      logic tlvl;   // 4
      logic tpol;   // 3
      logic ten;    // 2
      logic sie;    // 1
      logic sflg;   // 0
   } ctrl_t;

   // {level, polarity}
   typedef enum logic [1:0] {
      TRIG_FALL = 2'b00,
      TRIG_RISE = 2'b01,
      TRIG_LOW  = 2'b10,
      TRIG_HIGH = 2'b11
   } trig_mode_t;

endpackage

// File: rtl/adc_trig_cond.sv
module adc_trig_cond
   import adc_ctrl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic       enable,
   input  trig_mode_t mode,
   output logic       hit
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("adc_trig_cond: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   sy;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign sy = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sy;
   end

   always_comb begin
      hit = 1'b0;
      if (enable) begin
         unique case (mode)
            TRIG_FALL: hit = ~sy & prev_q;
            TRIG_RISE: hit = sy & ~prev_q;
            TRIG_LOW:  hit = ~sy;
            TRIG_HIGH: hit = sy;
            default:   hit = 1'b0;
         endcase
      end
   end

   // R11
   edge_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !mode[1]) |=> (!hit || mode[1]));

endmodule

// File: rtl/adc_power_seq.sv
module adc_power_seq #(
   parameter int RECOVERY_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_bit,
   input  logic wpd_bit,
   input  logic wait_enter,
   input  logic wake,
   output logic power_on,
   output logic halt,
   output logic ready
);

   localparam int CNT_W = $clog2(RECOVERY_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RECOVERY_CYCLES);

   if (RECOVERY_CYCLES < 1) begin : g_bad_rec
      $error("adc_power_seq: RECOVERY_CYCLES must be at least 1");
   end

   logic             in_wait_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          in_wait_q <= 1'b0;
      else if (wake)       in_wait_q <= 1'b0;
      else if (wait_enter) in_wait_q <= 1'b1;
   end

   assign halt     = pwr_bit & wpd_bit & in_wait_q;
   assign power_on = pwr_bit & ~halt;

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= CNT_LOAD;
      else if (!power_on)        cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign ready = power_on & (cnt_q == '0);

   // R4
   power_rise_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(power_on) |-> !ready);

   // R9
   wait_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait_q && wpd_bit && pwr_bit && !wake) |=> !ready);

endmodule

// File: rtl/adc_flag_bank.sv
module adc_flag_bank #(
   parameter int NUM_RESULTS = 16,
   parameter int DATA_W      = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                ready,
   input  logic                                fast,
   input  logic                                any_wr,
   input  logic [NUM_RESULTS-1:0]              done,
   input  logic [DATA_W-1:0]                   data_in,
   input  logic [NUM_RESULTS-1:0]              stat_rd,
   input  logic [NUM_RESULTS-1:0]              res_rd,
   input  logic [NUM_RESULTS-1:0]              res_acc,
   output logic [NUM_RESULTS-1:0]              ccf,
   output logic [NUM_RESULTS-1:0][DATA_W-1:0]  result
);

   logic [NUM_RESULTS-1:0] armed_q;
   logic [NUM_RESULTS-1:0] set_v;
   logic [NUM_RESULTS-1:0] clr_v;

   for (genvar i = 0; i < NUM_RESULTS; i++) begin : g_slot
      assign set_v[i] = done[i] & ready;
      assign clr_v[i] = fast ? res_acc[i] : (res_rd[i] & armed_q[i]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ccf[i]     <= 1'b0;
            armed_q[i] <= 1'b0;
            result[i]  <= '0;
         end else begin
            ccf[i] <= set_v[i] | (ccf[i] & ~clr_v[i]);
            if (any_wr || clr_v[i])          armed_q[i] <= 1'b0;
            else if (stat_rd[i] && ccf[i])   armed_q[i] <= 1'b1;
            if (set_v[i])                    result[i]  <= data_in;
         end
      end

      // R6
      flag_clear_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ccf[i]) |-> $past(res_acc[i]));

      // R5
      strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (done[i] && !ready && !res_acc[i]) |=> $stable(ccf[i]));
   end

endmodule

// File: rtl/adc_ctrl_front.sv
module adc_ctrl_front
   import adc_ctrl_pkg::*;
#(
   parameter int NUM_RESULTS     = 16,
   parameter int DATA_W          = 8,
   parameter int ADDR_W          = 6,
   parameter int STAT_BASE       = 2,
   parameter int RES_BASE        = 32,
   parameter int RECOVERY_CYCLES = 64,
   parameter int SYNC_STAGES     = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [7:0]              bus_wdata,
   output logic [7:0]              bus_rdata,
   input  logic                    wait_enter,
   input  logic                    wake,
   input  logic                    ext_trig_pin,
   input  logic [NUM_RESULTS-1:0]  conv_done,
   input  logic [DATA_W-1:0]       conv_data,
   input  logic                    seq_done,
   output logic                    seq_abort,
   output logic                    seq_halt,
   output logic                    conv_power,
   output logic                    conv_ready,
   output logic                    trig_start,
   output logic                    ch15_is_trig,
   output logic                    irq
);

   localparam int STAT_BYTES = (NUM_RESULTS + BUS_W - 1) / BUS_W;
   localparam int PAD_W      = STAT_BYTES * BUS_W;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

   if (NUM_RESULTS < 1 || DATA_W < 1 || DATA_W > BUS_W || STAT_BASE < 1 ||
       RES_BASE < STAT_BASE + STAT_BYTES || RES_BASE + NUM_RESULTS > (1 << ADDR_W)) begin : g_bad_cfg
      $error("adc_ctrl_front: address map or widths inconsistent");
   end

   ctrl_t                             ctrl_q;
   logic                              ctrl_wr;
   logic                              any_wr;
   logic                              abort_q;
   logic                              trig_hit;
   logic [NUM_RESULTS-1:0]            ccf;
   logic [NUM_RESULTS-1:0][DATA_W-1:0] result;
   logic [NUM_RESULTS-1:0]            stat_rd;
   logic [NUM_RESULTS-1:0]            res_acc;
   logic [NUM_RESULTS-1:0]            res_rd;
   logic [PAD_W-1:0]                  ccf_pad;

   assign any_wr  = bus_sel & bus_wr;
   assign ctrl_wr = any_wr & (bus_addr == CTRL_ADDR);

   for (genvar i = 0; i < NUM_RESULTS; i++) begin : g_dec
      assign stat_rd[i] = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(STAT_BASE + i / BUS_W));
      assign res_acc[i] = bus_sel & (bus_addr == ADDR_W'(RES_BASE + i));
      assign res_rd[i]  = res_acc[i] & ~bus_wr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         abort_q <= 1'b0;
      end else begin
         abort_q <= ctrl_wr;
         if (ctrl_wr)                      ctrl_q <= ctrl_t'({bus_wdata[7:1], 1'b0});
         else if (seq_done && conv_ready)  ctrl_q.sflg <= 1'b1;
      end
   end

   adc_power_seq #(
      .RECOVERY_CYCLES (RECOVERY_CYCLES)
   ) u_power (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_bit    (ctrl_q.pwr),
      .wpd_bit    (ctrl_q.wpd),
      .wait_enter (wait_enter),
      .wake       (wake),
      .power_on   (conv_power),
      .halt       (seq_halt),
      .ready      (conv_ready)
   );

   adc_trig_cond #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (ext_trig_pin),
      .enable (ctrl_q.ten),
      .mode   (trig_mode_t'({ctrl_q.tlvl, ctrl_q.tpol})),
      .hit    (trig_hit)
   );

   adc_flag_bank #(
      .NUM_RESULTS (NUM_RESULTS),
      .DATA_W      (DATA_W)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready   (conv_ready),
      .fast    (ctrl_q.ffc),
      .any_wr  (any_wr),
      .done    (conv_done),
      .data_in (conv_data),
      .stat_rd (stat_rd),
      .res_rd  (res_rd),
      .res_acc (res_acc),
      .ccf     (ccf),
      .result  (result)
   );

   assign trig_start   = trig_hit & conv_ready & ~ctrl_wr;
   assign ch15_is_trig = ctrl_q.ten;
   assign seq_abort    = abort_q;
   assign irq          = ctrl_q.sie & ctrl_q.sflg;
   assign ccf_pad      = PAD_W'(ccf);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == CTRL_ADDR) bus_rdata = ctrl_q;
      for (int b = 0; b < STAT_BYTES; b++) begin
         if (bus_addr == ADDR_W'(STAT_BASE + b)) bus_rdata = ccf_pad[b*BUS_W +: BUS_W];
      end
      for (int r = 0; r < NUM_RESULTS; r++) begin
         if (bus_addr == ADDR_W'(RES_BASE + r)) bus_rdata = BUS_W'(result[r]);
      end
   end

   // R3
   ctrl_write_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (seq_abort && !irq));

   // R3
   abort_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_abort && !ctrl_wr) |=> !seq_abort);

   // R13
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(seq_done && conv_ready));

endmodule

// File: tb/adc_ctrl_front_test.sv
module adc_ctrl_front_test;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 12;
   localparam int REC        = 5;
   localparam int ADDR_W     = 6;
   localparam int STAT_BASE  = 2;
   localparam int RES_BASE   = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0, bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        bus_rdata;
   logic              wait_enter = 1'b0, wake = 1'b0, ext_trig_pin = 1'b0;
   logic [N-1:0]      conv_done = '0;
   logic [7:0]        conv_data = '0;
   logic              seq_done = 1'b0;
   logic              seq_abort, seq_halt, conv_power, conv_ready;
   logic              trig_start, ch15_is_trig, irq;

   int n_chk = 0;
   int n_fail = 0;

   logic [N-1:0] m_ccf, m_arm;
   logic [7:0]   m_data [N];
   logic         m_fast;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_ctrl_front #(
      .NUM_RESULTS (N), .DATA_W (8), .ADDR_W (ADDR_W), .STAT_BASE (STAT_BASE),
      .RES_BASE (RES_BASE), .RECOVERY_CYCLES (REC), .SYNC_STAGES (2)
   ) uut (
      .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .wait_enter (wait_enter), .wake (wake), .ext_trig_pin (ext_trig_pin),
      .conv_done (conv_done), .conv_data (conv_data), .seq_done (seq_done),
      .seq_abort (seq_abort), .seq_halt (seq_halt), .conv_power (conv_power),
      .conv_ready (conv_ready), .trig_start (trig_start),
      .ch15_is_trig (ch15_is_trig), .irq (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_stat(input int b);
      logic [15:0] p;
      p = 16'(m_ccf);
      return p[b*8 +: 8];
   endfunction

   task automatic bus_write(input int a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic strobe(input int i, input logic [7:0] d);
      @(negedge clk);
      conv_done = '0; conv_done[i] = 1'b1; conv_data = d;
      @(negedge clk);
      conv_done = '0;
   endtask

   task automatic pulse_seq_done();
      @(negedge clk); seq_done = 1'b1;
      @(negedge clk); seq_done = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(0, rd);            chk("R1 ctrl", rd, 8'h00);
      bus_read(STAT_BASE, rd);    chk("R1 stat0", rd, 8'h00);
      bus_read(STAT_BASE + 1, rd); chk("R1 stat1", rd, 8'h00);
      chk("R1 outs", {conv_power, conv_ready, seq_abort, seq_halt, trig_start, irq}, 6'b0);

      // R4 power-up and recovery; R3 abort pulse; R2 bit0 read-only
      bus_write(0, 8'h81);
      chk("R3 abort", seq_abort, 1'b1);
      chk("R4 power", conv_power, 1'b1);
      chk("R4 not ready", conv_ready, 1'b0);
      // R5 strobe during recovery is dropped
      strobe(3, 8'h33);
      idle(REC - 3);
      chk("R4 ready late", conv_ready, 1'b0);
      idle(1);
      chk("R4 ready on time", conv_ready, 1'b1);
      bus_read(STAT_BASE, rd);    chk("R5 no flag", rd, 8'h00);
      bus_read(0, rd);            chk("R2 readback", rd, 8'h80);
      chk("R3 abort single", seq_abort, 1'b0);
      chk("R3 no start", trig_start, 1'b0);

      // R6 normal clear pairing, R14 data
      strobe(5, 8'hA5);
      bus_read(RES_BASE + 5, rd); chk("R14 data", rd, 8'hA5);
      bus_read(STAT_BASE, rd);    chk("R6 unpaired read keeps flag", rd, 8'h20);
      bus_read(RES_BASE + 5, rd);
      bus_read(STAT_BASE, rd);    chk("R6 paired clear", rd, 8'h00);

      // R7 intervening write disarms
      strobe(10, 8'h5A);
      bus_read(STAT_BASE + 1, rd); chk("R6 upper bits", rd, 8'h04);
      bus_write(0, 8'h80);
      bus_read(RES_BASE + 10, rd); chk("R14 data10", rd, 8'h5A);
      bus_read(STAT_BASE + 1, rd); chk("R7 disarmed", rd, 8'h04);

      // R8 fast clear by read and by write
      bus_write(0, 8'hC0);
      strobe(9, 8'h99);
      bus_read(RES_BASE + 9, rd);
      bus_read(STAT_BASE + 1, rd); chk("R8 read clears", rd, 8'h04);
      bus_write(RES_BASE + 10, 8'hFF);
      bus_read(STAT_BASE + 1, rd); chk("R8 write clears", rd, 8'h00);
      bus_read(RES_BASE + 10, rd); chk("R14 write ignored", rd, 8'h5A);

      // R12 trigger disabled
      bus_write(0, 8'h88);
      chk("R12 ch15 off", ch15_is_trig, 1'b0);
      @(negedge clk); ext_trig_pin = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); chk("R12 no start", trig_start, 1'b0);
      end
      ext_trig_pin = 1'b0; idle(4);

      // R11 rising edge
      bus_write(0, 8'h8C);
      chk("R12 ch15 on", ch15_is_trig, 1'b1);
      @(negedge clk); ext_trig_pin = 1'b1;
      @(negedge clk); chk("R11 rise sync", trig_start, 1'b0);
      @(negedge clk); chk("R11 rise pulse", trig_start, 1'b1);
      @(negedge clk); chk("R11 rise single", trig_start, 1'b0);

      // R11 falling edge
      bus_write(0, 8'h84);
      @(negedge clk); ext_trig_pin = 1'b0;
      @(negedge clk); chk("R11 fall sync", trig_start, 1'b0);
      @(negedge clk); chk("R11 fall pulse", trig_start, 1'b1);
      @(negedge clk); chk("R11 fall single", trig_start, 1'b0);

      // R11 low level
      ext_trig_pin = 1'b1; idle(3);
      bus_write(0, 8'h94);
      chk("R11 low idle", trig_start, 1'b0);
      @(negedge clk); ext_trig_pin = 1'b0;
      idle(2);
      chk("R11 low active", trig_start, 1'b1);
      idle(2);
      chk("R11 low held", trig_start, 1'b1);
      // R11 high level
      bus_write(0, 8'h9C);
      chk("R11 high idle", trig_start, 1'b0);
      ext_trig_pin = 1'b1; idle(3);
      chk("R11 high active", trig_start, 1'b1);
      ext_trig_pin = 1'b0;

      // R9 wait without power-down
      bus_write(0, 8'h80);
      @(negedge clk); wait_enter = 1'b1;
      @(negedge clk); wait_enter = 1'b0;
      chk("R9 no halt", {seq_halt, conv_power, conv_ready}, 3'b011);
      @(negedge clk); wake = 1'b1;
      @(negedge clk); wake = 1'b0;

      // R9 wait with power-down, R10 wake recovery
      bus_write(0, 8'hA0);
      idle(REC + 1);
      @(negedge clk); wait_enter = 1'b1;
      @(negedge clk); wait_enter = 1'b0;
      chk("R9 halt", {seq_halt, conv_power}, 2'b10);
      strobe(1, 8'h11);
      @(negedge clk); wake = 1'b1;
      @(negedge clk); wake = 1'b0;
      chk("R10 power back", {seq_halt, conv_power, conv_ready}, 3'b010);
      strobe(2, 8'h22);
      idle(REC);
      chk("R10 ready again", conv_ready, 1'b1);
      bus_read(STAT_BASE, rd); chk("R10 first results dropped", rd, 8'h00);

      // R13 sequence flag and interrupt
      bus_write(0, 8'h82);
      pulse_seq_done();
      chk("R13 irq", irq, 1'b1);
      bus_read(0, rd); chk("R13 flag", rd, 8'h83);
      bus_write(0, 8'h82);
      chk("R3 flag cleared", irq, 1'b0);
      bus_write(0, 8'h80);
      pulse_seq_done();
      bus_read(0, rd); chk("R13 flag no ie", rd, 8'h81);
      chk("R13 irq masked", irq, 1'b0);

      // random phase: prime every slot
      bus_write(0, 8'h80);
      m_fast = 1'b0; m_arm = '0; m_ccf = '0;
      for (int i = 0; i < N; i++) begin
         m_data[i] = 8'($urandom);
         strobe(i, m_data[i]);
         m_ccf[i] = 1'b1;
      end
      for (int op = 0; op < 600; op++) begin
         int sel;
         int i;
         int b;
         sel = int'($urandom % 6);
         i   = int'($urandom % N);
         b   = int'($urandom % 2);
         case (sel)
            0: begin
               m_data[i] = 8'($urandom);
               strobe(i, m_data[i]);
               m_ccf[i] = 1'b1;
            end
            1, 2: begin
               bus_read(STAT_BASE + b, rd);
               chk("R6 status", rd, exp_stat(b));
               for (int k = b*8; k < b*8 + 8 && k < N; k++)
                  if (m_ccf[k]) m_arm[k] = 1'b1;
            end
            3: begin
               bus_read(RES_BASE + i, rd);
               chk("R14 result", rd, m_data[i]);
               if (m_fast || m_arm[i]) begin m_ccf[i] = 1'b0; m_arm[i] = 1'b0; end
            end
            4: begin
               bus_write(RES_BASE + i, 8'($urandom));
               m_arm = '0;
               if (m_fast) m_ccf[i] = 1'b0;
            end
            default: begin
               m_fast = 1'($urandom);
               bus_write(0, {1'b1, m_fast, 6'b0});
               m_arm = '0;
               chk("R8 ready kept", conv_ready, 1'b1);
            end
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule